// File: doc/BRIEF.md
# Word-Framed SPI Flash Master

This block is a register-programmed SPI master meant to drive a serial flash device. Software sets up each chip-select window with two configuration words. The transmit word gives how many words go out and how many bits each word has. The receive word gives the same two values for the reply. Transmit data is written into a FIFO. Received words gather in a second FIFO, where they are right-aligned. A status word lets software poll for FIFO space, for received data and for activity on the bus.

A transaction starts once the block is idle, the transmit word count is non-zero and the transmit FIFO holds at least one word. Chip select then goes low and stays low for the whole window. During that window all transmit words go out MSB first, and after them the programmed number of receive words is clocked in. Chip select goes high at the end. The block then stays busy until a programmable number of system clocks has passed, and only after that can the next window open. A divider sets the SCK rate. The bus runs in SPI mode 0.

Top module: `spi_wc_master`

## Requirements
- R1: After reset, SCK is low, chip select is high, MOSI is low, the status word reads 0x05 and the CS-latency register (offset 0x18) reads 32.
- R2: The TX configuration word (offset 0x10) and the RX configuration word (offset 0x14) each hold a word count in bits [31:16] and a word length in bits [5:0], valid from 1 to 32 (8 gives bytes, 0x20 gives 32-bit words). A window opens only when the TX count is non-zero and the TX FIFO is not empty. While the TX count is zero, queued words wait and chip select stays high.
- R3: Each TX word written at offset 0x20 is sent MSB first, using its low "length" bits. All TX words go out before any RX bit is clocked in. Chip select stays low for the whole window, including while the engine waits for late TX data. MOSI is low during the receive phase.
- R4: The RX phase takes in "count" words of "length" bits, sampled on rising SCK and right-aligned. Each read at offset 0x24 pops one word. An RX count of zero receives nothing. A read with the RX FIFO empty returns 0.
- R5: The RX configuration is kept after a transaction, so the next window receives the same number of words unless software rewrites it.
- R6: Status at offset 0x38: bit0 TX FIFO empty, bit1 TX FIFO full, bit2 RX FIFO empty, bit3 RX FIFO full, bit4 received word available, bit5 busy.
- R7: Mode 0: MOSI changes only while SCK is low, and SCK stays low while chip select is high.
- R8: With value N in the divider register (offset 0x08), each SCK high phase and each low phase inside a word lasts N+1 system clocks. N=0 gives SCK at half the system clock.
- R9: Chip select stays high for at least the CS-latency count of system clocks between windows. Busy is set from the chip-select fall until that count has expired after chip select rises.
- R10: The TX FIFO holds 16 words. A write to it while it is full is dropped.
- R11: The RX FIFO holds 16 words. When it is full, the engine pauses with chip select low and no SCK edges, and resumes when a word is read, so no data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at offset 0x24) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A behavioural slave in the bench watches SCK edges and records MOSI. It answers from a queued bit stream only after the programmed number of command bits has gone by. This keeps the transmit phase and the receive phase of a window apart, so a swap or overlap of the two shows up. The patterns are: a single byte command with no reply, a 32-bit command with a byte-wise reply, a 32-bit reply at a slower divider, three command bytes fed slowly, two windows queued back to back, a full transmit FIFO released by a count change, and a reply longer than the receive FIFO. Each one separates a different fault: framing by word length, merged or split windows, divider timing, ignored latency, dropped overflow words and lost receive words.

// File: rtl/spi_wc_pkg.sv
package spi_wc_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned LEN_W  = 6;

   // register byte offsets
   localparam logic [7:0] OFS_DIV   = 8'h08;
   localparam logic [7:0] OFS_TXCFG = 8'h10;
   localparam logic [7:0] OFS_RXCFG = 8'h14;
   localparam logic [7:0] OFS_CSLAT = 8'h18;
   localparam logic [7:0] OFS_TXDAT = 8'h20;
   localparam logic [7:0] OFS_RXDAT = 8'h24;
   localparam logic [7:0] OFS_STAT  = 8'h38;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_TX,
      ST_RX,
      ST_PUSH,
      ST_GAP
   } eng_state_t;

   // a length field of 0 or above 32 falls back to full words
   function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] f);
      if (f == '0 || f > LEN_W'(WORD_W)) return LEN_W'(WORD_W);
      return f;
   endfunction

endpackage

// File: rtl/spi_wc_fifo.sv
module spi_wc_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_wc_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_wc_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt_q;
   logic             wr_en, rd_en;

   assign wr_en = push && !full;
   assign rd_en = pop && !empty;

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   // R10
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);

endmodule

// File: rtl/spi_wc_clkdiv.sv
module spi_wc_clkdiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("spi_wc_clkdiv: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || tick)   cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R8
   div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= div));

endmodule

// File: rtl/spi_wc_engine.sv
module spi_wc_engine
   import spi_wc_pkg::*;
#(
   parameter int unsigned DIV_W = 8,
   parameter int unsigned LAT_W = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   div,
   input  logic [LAT_W-1:0]   cs_lat,
   input  logic [CNT_W-1:0]   tx_cnt,
   input  logic [LEN_W-1:0]   tx_len,
   input  logic [CNT_W-1:0]   rx_cnt,
   input  logic [LEN_W-1:0]   rx_len,
   input  logic               txf_empty,
   input  logic [WORD_W-1:0]  txf_data,
   output logic               txf_pop,
   input  logic               rxf_full,
   output logic               rxf_push,
   output logic [WORD_W-1:0]  rxf_data,
   output logic               sck,
   output logic               cs_n,
   output logic               mosi,
   input  logic               miso,
   output logic               busy
);

   eng_state_t         state_q;
   logic               sck_q, cs_n_q, tick, run;
   logic [WORD_W-1:0]  sh_q, rsh_q;
   logic [LEN_W-1:0]   bit_q, l_txl, l_rxl;
   logic [CNT_W-1:0]   wcnt_q, wnext, l_txc, l_rxc;
   logic [LAT_W-1:0]   gcnt_q;

   assign run   = (state_q == ST_TX) || (state_q == ST_RX);
   assign wnext = wcnt_q + 1'b1;

   spi_wc_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (div),
      .tick  (tick)
   );

   assign txf_pop  = (state_q == ST_LOAD) && !txf_empty;
   assign rxf_push = (state_q == ST_PUSH) && !rxf_full;
   assign rxf_data = rsh_q;
   assign sck      = sck_q;
   assign cs_n     = cs_n_q;
   assign mosi     = (state_q == ST_TX) ? sh_q[WORD_W-1] : 1'b0;
   assign busy     = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
         sh_q    <= '0;
         rsh_q   <= '0;
         bit_q   <= '0;
         wcnt_q  <= '0;
         gcnt_q  <= '0;
         l_txc   <= '0;
         l_rxc   <= '0;
         l_txl   <= LEN_W'(WORD_W);
         l_rxl   <= LEN_W'(WORD_W);
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (tx_cnt != '0 && !txf_empty) begin
                  l_txc   <= tx_cnt;
                  l_rxc   <= rx_cnt;
                  l_txl   <= tx_len;
                  l_rxl   <= rx_len;
                  wcnt_q  <= '0;
                  cs_n_q  <= 1'b0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (!txf_empty) begin
                  sh_q    <= txf_data << (LEN_W'(WORD_W) - l_txl);
                  bit_q   <= '0;
                  state_q <= ST_TX;
               end
            end
            ST_TX: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     bit_q <= bit_q + 1'b1;
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_q == l_txl) begin
                        wcnt_q <= wnext;
                        if (wnext == l_txc) begin
                           wcnt_q <= '0;
                           if (l_rxc != '0) begin
                              bit_q   <= '0;
                              rsh_q   <= '0;
                              state_q <= ST_RX;
                           end else begin
                              cs_n_q  <= 1'b1;
                              gcnt_q  <= '0;
                              state_q <= ST_GAP;
                           end
                        end else begin
                           state_q <= ST_LOAD;
                        end
                     end else begin
                        sh_q <= sh_q << 1;
                     end
                  end
               end
            end
            ST_RX: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     rsh_q <= {rsh_q[WORD_W-2:0], miso};
                     bit_q <= bit_q + 1'b1;
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_q == l_rxl) state_q <= ST_PUSH;
                  end
               end
            end
            ST_PUSH: begin
               if (!rxf_full) begin
                  if (wnext == l_rxc) begin
                     cs_n_q  <= 1'b1;
                     gcnt_q  <= '0;
                     state_q <= ST_GAP;
                  end else begin
                     wcnt_q  <= wnext;
                     bit_q   <= '0;
                     rsh_q   <= '0;
                     state_q <= ST_RX;
                  end
               end
            end
            ST_GAP: begin
               if (gcnt_q >= cs_lat) state_q <= ST_IDLE;
               else                  gcnt_q  <= gcnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // checker state: chip-select high time, saturating
   logic [LAT_W:0] hi_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_q <= '1;
      else if (!cs_n_q)   hi_q <= '0;
      else if (hi_q != '1) hi_q <= hi_q + 1'b1;
   end

   // R7
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sck_q);

   // R7
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> (mosi == $past(mosi)));

   // R9
   busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_q |-> busy);

   // R9
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_q) |-> (hi_q >= {1'b0, cs_lat}));

   // R11
   rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PUSH) && rxf_full) |=> ((state_q == ST_PUSH) && !cs_n_q && !sck_q));

endmodule

// File: rtl/spi_wc_master.sv
module spi_wc_master
   import spi_wc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned LAT_W      = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned LAT_RESET  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int unsigned ST_BITS = 6;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_wc_master: ADDR_W must cover offset 0x38");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("spi_wc_master: CNT_W must be 1..16");
   end
   if (DIV_W > 32 || LAT_W > 32 || LAT_W < 1) begin : g_bad_reg
      $error("spi_wc_master: DIV_W and LAT_W must fit a 32-bit register");
   end
   if (LAT_RESET >= (1 << LAT_W)) begin : g_bad_lat
      $error("spi_wc_master: LAT_RESET does not fit LAT_W");
   end

   logic [DIV_W-1:0]   div_q;
   logic [31:0]        txcfg_q, rxcfg_q;
   logic [LAT_W-1:0]   lat_q;

   logic               txf_push, txf_pop, txf_empty, txf_full;
   logic               rxf_push, rxf_pop, rxf_empty, rxf_full;
   logic [WORD_W-1:0]  txf_data, rxf_wdata, rxf_rdata;
   logic               busy;
   logic [ST_BITS-1:0] status;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         txcfg_q <= '0;
         rxcfg_q <= '0;
         lat_q   <= LAT_W'(LAT_RESET);
      end else if (reg_wr) begin
         if (hit(reg_addr, OFS_DIV))   div_q   <= reg_wdata[DIV_W-1:0];
         if (hit(reg_addr, OFS_TXCFG)) txcfg_q <= reg_wdata;
         if (hit(reg_addr, OFS_RXCFG)) rxcfg_q <= reg_wdata;
         if (hit(reg_addr, OFS_CSLAT)) lat_q   <= reg_wdata[LAT_W-1:0];
      end
   end

   assign txf_push = reg_wr && hit(reg_addr, OFS_TXDAT);
   assign rxf_pop  = reg_rd && hit(reg_addr, OFS_RXDAT);

   spi_wc_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (txf_push),
      .wdata (reg_wdata),
      .pop   (txf_pop),
      .rdata (txf_data),
      .empty (txf_empty),
      .full  (txf_full)
   );

   spi_wc_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rxf_push),
      .wdata (rxf_wdata),
      .pop   (rxf_pop),
      .rdata (rxf_rdata),
      .empty (rxf_empty),
      .full  (rxf_full)
   );

   spi_wc_engine #(.DIV_W(DIV_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .div       (div_q),
      .cs_lat    (lat_q),
      .tx_cnt    (txcfg_q[16 +: CNT_W]),
      .tx_len    (eff_len(txcfg_q[LEN_W-1:0])),
      .rx_cnt    (rxcfg_q[16 +: CNT_W]),
      .rx_len    (eff_len(rxcfg_q[LEN_W-1:0])),
      .txf_empty (txf_empty),
      .txf_data  (txf_data),
      .txf_pop   (txf_pop),
      .rxf_full  (rxf_full),
      .rxf_push  (rxf_push),
      .rxf_data  (rxf_wdata),
      .sck       (spi_sck),
      .cs_n      (spi_cs_n),
      .mosi      (spi_mosi),
      .miso      (spi_miso),
      .busy      (busy)
   );

   assign status = {busy, !rxf_empty, rxf_full, rxf_empty, txf_full, txf_empty};

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFS_DIV))   reg_rdata = 32'(div_q);
      if (hit(reg_addr, OFS_TXCFG)) reg_rdata = txcfg_q;
      if (hit(reg_addr, OFS_RXCFG)) reg_rdata = rxcfg_q;
      if (hit(reg_addr, OFS_CSLAT)) reg_rdata = 32'(lat_q);
      if (hit(reg_addr, OFS_RXDAT)) reg_rdata = rxf_empty ? '0 : rxf_rdata;
      if (hit(reg_addr, OFS_STAT))  reg_rdata = 32'(status);
   end

   // R4
   rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_pop && rxf_empty) |-> (reg_rdata == '0));

   // R2
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && txcfg_q[16 +: CNT_W] == '0) |=> spi_cs_n);

endmodule

// File: tb/tb_spi_wc_master.sv
module tb_spi_wc_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   always #5 clk = ~clk;

   spi_wc_master dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .spi_sck   (spi_sck),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // behavioural slave / monitor state
   bit   cap[$];
   bit   resp[$];
   int   txbits = 0, rc = 0, cs_falls = 0;
   int   hi_run = 0, last_hi = 0, cs_hi_run = 0, last_gap = 0;
   int   cyc = 0, rise_cyc = 0;
   int   v_idle = 0, v_mosi = 0, v_rxmosi = 0;
   logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

   always @(negedge clk) begin
      int k;
      cyc++;
      if (rst_n) begin
         if (spi_cs_n && spi_sck) v_idle++;
         if (p_sck && spi_sck && spi_mosi != p_mosi) v_mosi++;
         if (p_cs && !spi_cs_n) begin
            cs_falls++;
            rc = 0;
            last_gap = cs_hi_run;
         end
         if (!p_cs && spi_cs_n) rise_cyc = cyc;
         if (spi_cs_n) cs_hi_run++; else cs_hi_run = 0;
         if (!p_sck && spi_sck && !spi_cs_n) begin
            if (rc < txbits) cap.push_back(spi_mosi);
            else if (spi_mosi) v_rxmosi++;
            rc++;
         end
         if (spi_sck) hi_run++;
         else begin
            if (p_sck) last_hi = hi_run;
            hi_run = 0;
         end
         k = rc - txbits;
         spi_miso = (k >= 0 && k < resp.size()) ? resp[k] : 1'b0;
      end
      p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      int n = 0;
      do begin
         rd(8'h38, s);
         n++;
      end while (!(s[0] && !s[5]) && n < 3000);
      check(n < 3000, req, s, 32'h1);
   endtask

   task automatic wait_status_bit(input int b, input string req);
      logic [31:0] s;
      int n = 0;
      do begin
         rd(8'h38, s);
         n++;
      end while (!s[b] && n < 3000);
      check(n < 3000, req, s, 32'(1 << b));
   endtask

   function automatic logic [31:0] cap_word(input int start, input int n);
      logic [31:0] r = '0;
      for (int i = 0; i < n; i++) r = {r[30:0], cap[start + i]};
      return r;
   endfunction

   task automatic add_resp(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) resp.push_back(v[i]);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog R1..all: actual hung expected completion");
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      int cf;
      logic [7:0] rb [17];
      logic [31:0] resp3 [3];

      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // ---- reset state
      check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 pins",
            {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'h4);
      rd(8'h38, d); check(d == 32'h05, "R1 R6 reset status", d, 32'h05);
      rd(8'h18, d); check(d == 32'd32, "R1 R9 cs latency reset", d, 32'd32);
      rd(8'h24, d); check(d == 32'h0, "R4 empty rx read", d, 32'h0);

      // ---- single byte command, no reply
      cap.delete(); resp.delete(); txbits = 8; cf = cs_falls;
      wr(8'h10, 32'h0001_0008);
      wr(8'h14, 32'h0000_0000);
      wr(8'h20, 32'h1234_5606);
      wait_idle("R2 byte cmd done");
      check(cap.size() == 8 && cap_word(0, 8) == 32'h06, "R2 R3 byte msb first",
            cap_word(0, 8), 32'h06);
      rd(8'h38, d); check(d == 32'h05, "R4 R6 no rx with zero count", d, 32'h05);
      check(cs_falls == cf + 1, "R3 one window", cs_falls, cf + 1);
      check(last_hi == 1, "R8 div 0 high phase", last_hi, 1);

      // ---- 32-bit command, three byte reply
      cap.delete(); resp.delete(); txbits = 32; cf = cs_falls;
      resp3[0] = 32'hA1; resp3[1] = 32'h5B; resp3[2] = 32'hC7;
      for (int i = 0; i < 3; i++) add_resp(resp3[i], 8);
      wr(8'h10, 32'h0001_0020);
      wr(8'h14, 32'h0003_0008);
      wr(8'h20, 32'h0BAD_F00D);
      wait_idle("R3 cmd+reply done");
      check(cap.size() == 32 && cap_word(0, 32) == 32'h0BAD_F00D, "R3 32-bit word",
            cap_word(0, 32), 32'h0BAD_F00D);
      check(cs_falls == cf + 1, "R3 tx and rx in one window", cs_falls, cf + 1);
      rd(8'h38, d); check(d == 32'h11, "R6 word available", d, 32'h11);
      for (int i = 0; i < 3; i++) begin
         rd(8'h24, d); check(d == resp3[i], "R4 byte reply", d, resp3[i]);
      end

      // ---- reply count persists
      cap.delete();
      wr(8'h20, 32'h0000_0042);
      wait_idle("R5 repeat done");
      for (int i = 0; i < 3; i++) begin
         rd(8'h24, d); check(d == resp3[i], "R5 rx config kept", d, resp3[i]);
      end
      rd(8'h24, d); check(d == 32'h0, "R4 read after drain", d, 32'h0);

      // ---- slower divider, 32-bit reply words
      cap.delete(); resp.delete(); txbits = 32;
      add_resp(32'hDEAD_BEEF, 32); add_resp(32'h0123_4567, 32);
      wr(8'h08, 32'd2);
      wr(8'h10, 32'h0001_0020);
      wr(8'h14, 32'h0002_0020);
      wr(8'h20, 32'hA5C3_0F96);
      wait_idle("R8 slow done");
      check(cap_word(0, 32) == 32'hA5C3_0F96, "R3 cmd at div 2", cap_word(0, 32), 32'hA5C3_0F96);
      check(last_hi == 3, "R8 div 2 high phase", last_hi, 3);
      rd(8'h24, d); check(d == 32'hDEAD_BEEF, "R4 32-bit reply 0", d, 32'hDEAD_BEEF);
      rd(8'h24, d); check(d == 32'h0123_4567, "R4 32-bit reply 1", d, 32'h0123_4567);
      wr(8'h08, 32'd0);

      // ---- three bytes fed slowly: one window
      cap.delete(); resp.delete(); txbits = 24; cf = cs_falls;
      wr(8'h10, 32'h0003_0008);
      wr(8'h14, 32'h0000_0008);
      wr(8'h20, 32'h11);
      repeat (40) @(posedge clk);
      check(spi_cs_n == 1'b0, "R3 cs held while waiting", spi_cs_n, 0);
      wr(8'h20, 32'h22);
      repeat (40) @(posedge clk);
      wr(8'h20, 32'h33);
      wait_idle("R3 slow feed done");
      check(cap_word(0, 24) == 32'h112233, "R3 three bytes", cap_word(0, 24), 32'h112233);
      check(cs_falls == cf + 1, "R3 slow feed one window", cs_falls, cf + 1);

      // ---- back-to-back windows with latency 12
      cap.delete(); txbits = 8; cf = cs_falls;
      wr(8'h18, 32'd12);
      wr(8'h10, 32'h0001_0008);
      wr(8'h20, 32'h5A);
      wr(8'h20, 32'hC3);
      wait_idle("R9 two windows done");
      check(cs_falls == cf + 2, "R9 two windows", cs_falls, cf + 2);
      check(cap_word(0, 16) == 32'h5AC3, "R3 two window bytes", cap_word(0, 16), 32'h5AC3);
      check(last_gap >= 12, "R9 cs high gap", last_gap, 12);
      check(cyc - rise_cyc >= 12, "R9 busy after cs rise", cyc - rise_cyc, 12);

      // ---- TX FIFO fill with count zero, overflow dropped
      cap.delete(); txbits = 128; cf = cs_falls;
      wr(8'h10, 32'h0000_0008);
      for (int i = 0; i < 17; i++) wr(8'h20, 32'h40 + i);
      rd(8'h38, d); check(d == 32'h06, "R10 R6 tx full", d, 32'h06);
      check(cs_falls == cf && spi_cs_n, "R2 zero count holds", cs_falls, cf);
      wr(8'h10, 32'h0010_0008);
      wait_idle("R10 burst done");
      for (int i = 0; i < 16; i++)
         check(cap_word(i * 8, 8) == 32'h40 + i, "R10 burst byte", cap_word(i * 8, 8), 32'h40 + i);
      rd(8'h38, d); check(d == 32'h05, "R10 overflow word dropped", d, 32'h05);

      // ---- reply longer than the RX FIFO
      cap.delete(); resp.delete(); txbits = 8;
      for (int i = 0; i < 17; i++) begin
         rb[i] = 8'((i * 7 + 3) ^ 8'h5C);
         add_resp(32'(rb[i]), 8);
      end
      wr(8'h10, 32'h0001_0008);
      wr(8'h14, 32'h0011_0008);
      wr(8'h20, 32'h05);
      wait_status_bit(3, "R11 rx fills");
      repeat (30) @(posedge clk);
      check(spi_cs_n == 1'b0, "R11 cs held while full", spi_cs_n, 0);
      rd(8'h38, d); check(d == 32'h39, "R11 R6 full status", d, 32'h39);
      for (int i = 0; i < 17; i++) begin
         wait_status_bit(4, "R11 word arrives");
         rd(8'h24, d); check(d == 32'(rb[i]), "R11 reply order", d, 32'(rb[i]));
      end
      wait_idle("R11 done");
      rd(8'h38, d); check(d == 32'h05, "R11 final status", d, 32'h05);

      // ---- protocol monitor totals
      check(v_idle == 0, "R7 sck low while cs high", v_idle, 0);
      check(v_mosi == 0, "R7 mosi stable while sck high", v_mosi, 0);
      check(v_rxmosi == 0, "R3 mosi low in reply", v_rxmosi, 0);

      done = 1;
      summary();
   end

endmodule